// File: doc/BRIEF.md
# Double-Buffered Clock Divider with Reload Trigger

This block divides its parent clock by a small programmable ratio and drives a divided clock level and a one-cycle tick that marks the start of each divided period. Software controls it through two 32-bit register words. The control word at offset 0x0 holds the gate enable, the reload-force bit and the global reload trigger. The ratio word at offset 0x8 holds the requested divide ratio.

A ratio written to the ratio word is only a shadow value. The divider starts using it after software sets the channel's reload-force bit and then raises the global trigger. Even then, the divider waits for the end of the current output period before it switches, so the output never carries a shortened or stretched pulse. Software can then clear the low control bits without touching the loaded ratio or the gate.

Top module: `clkdiv_reload_top`

## Requirements
- R1: After reset the control word reads 0x0000_0000, the ratio word reads 0x0000_0400 (ratio 4 in bits [13:8]), and div_clk_o and tick_o stay low.
- R2: A write with addr_i = 0x0 replaces the control word and a write with addr_i = 0x8 replaces the ratio word. rdata_o returns the stored word for the address on addr_i, and a word that is not written keeps its value.
- R3: The divided output runs only while control bit 25 (gate enable) is 1. While the bit is 0 the output stays low.
- R4: While running, the rising edges of div_clk_o are spaced by the active ratio in parent cycles. The high phase lasts floor(ratio/2) cycles, so an odd ratio has a high phase one cycle shorter than its low phase. tick_o is high in the first cycle of each period.
- R5: Writing the ratio word alone does not change the output period.
- R6: The field in ratio-word bits [13:8] becomes the new ratio only on a 0-to-1 change of control bit 8 (trigger) while control bit 1 (reload-force) is 1. Raising the trigger while bit 1 is 0, or setting bit 1 while the trigger is already 1, changes nothing.
- R7: Clearing control bits [8:0] after a reload leaves the loaded ratio and the gate enable in place.
- R8: A loaded ratio field below 4 becomes 4, a field above 6 (including 7) becomes 8, and 4, 5 and 6 are used unchanged.
- R9: A reloaded ratio takes effect at a period boundary, so every output period is either the old ratio or the new one.
- R10: When the gate enable is cleared, the output finishes its current period and then stays low with no further rising edge. After a later re-enable, div_clk_o goes high in the second cycle after the write and restarts a full period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Parent clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register byte offset (0x0 control, 0x8 ratio) |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Readback of the word selected by addr_i |
| div_clk_o | output | 1 | Divided clock level |
| tick_o | output | 1 | One-cycle pulse at the start of each divided period |

## Verification
The hardest case to reach from the ports is a reload that arrives in the middle of a running period. To reach it, the bench raises the trigger at arbitrary phases of the divider. It then times several consecutive periods and requires each one to match either the old ratio or the new one exactly. Constrained random ratio fields across the full 6-bit range exercise the clamp edges and mid-period reloads. Directed sequences cover a trigger with no force bit, a force bit set while the trigger is already high, and stopping and restarting the divider.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  localparam int unsigned DATA_W        = 32;
  localparam int unsigned RATIO_W       = 6;
  localparam int unsigned RATIO_MIN     = 4;
  localparam int unsigned RATIO_ODD_TOP = 6;
  localparam int unsigned RATIO_MAX     = 8;

  function automatic logic [RATIO_W-1:0] clamp_ratio(input logic [RATIO_W-1:0] r);
    if (r < RATIO_W'(RATIO_MIN))     return RATIO_W'(RATIO_MIN);
    if (r > RATIO_W'(RATIO_ODD_TOP)) return RATIO_W'(RATIO_MAX);
    return r;
  endfunction
endpackage

// File: rtl/clkdiv_regs.sv
`timescale 1ns/1ps
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned CTRL_ADDR  = 0,
  parameter int unsigned RATIO_ADDR = 8,
  parameter int unsigned CH_IDX     = 1,
  parameter int unsigned EN_BASE    = 24,
  parameter int unsigned TRIG_BIT   = 8,
  parameter int unsigned RATIO_LSB  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               en_o,
  output logic               reload_o,
  output logic [RATIO_W-1:0] ratio_o
);
  localparam int unsigned EN_BIT = EN_BASE + CH_IDX;
  localparam logic [DATA_W-1:0] RATIO_RST = DATA_W'(RATIO_MIN) << RATIO_LSB;

  logic [DATA_W-1:0] ctrl_q, ratio_q;
  logic              trig_d_q;

  wire sel_ctrl  = (addr_i == ADDR_W'(CTRL_ADDR));
  wire sel_ratio = (addr_i == ADDR_W'(RATIO_ADDR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      ratio_q  <= RATIO_RST;
      trig_d_q <= 1'b0;
    end else begin
      trig_d_q <= ctrl_q[TRIG_BIT];
      if (we_i && sel_ctrl)  ctrl_q  <= wdata_i;
      if (we_i && sel_ratio) ratio_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_ctrl)       rdata_o = ctrl_q;
    else if (sel_ratio) rdata_o = ratio_q;
  end

  assign en_o     = ctrl_q[EN_BIT];
  // reload only on a fresh trigger edge with the channel's force bit set
  assign reload_o = ctrl_q[TRIG_BIT] & ~trig_d_q & ctrl_q[CH_IDX];
  assign ratio_o  = clamp_ratio(ratio_q[RATIO_LSB +: RATIO_W]);

  // R2
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && sel_ctrl) |=> $stable(ctrl_q));
  // R2
  ratio_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && sel_ratio) |=> $stable(ratio_q));
  // R6
  reload_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_o |=> !reload_o);
endmodule

// File: rtl/clkdiv_core.sv
`timescale 1ns/1ps
module clkdiv_core
  import clkdiv_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               reload_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               div_clk_o,
  output logic               tick_o
);
  logic [RATIO_W-1:0] act_q, pend_q, cnt_q;
  logic               pend_vld_q, run_q;

  wire last     = (cnt_q == act_q - RATIO_W'(1));
  wire boundary = !run_q || last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q      <= RATIO_W'(RATIO_MIN);
      pend_q     <= RATIO_W'(RATIO_MIN);
      pend_vld_q <= 1'b0;
      run_q      <= 1'b0;
      cnt_q      <= '0;
    end else begin
      if (reload_i) begin
        pend_q     <= ratio_i;
        pend_vld_q <= 1'b1;
      end
      if (boundary) begin
        cnt_q <= '0;
        run_q <= en_i;
        // swap only between periods; a reload in this cycle waits one more
        if (pend_vld_q && !reload_i) begin
          act_q      <= pend_q;
          pend_vld_q <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q + RATIO_W'(1);
      end
    end
  end

  assign div_clk_o = run_q && (cnt_q < (act_q >> 1));
  assign tick_o    = run_q && (cnt_q == '0);

  // R8
  act_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q == 6'd4) || (act_q == 6'd5) || (act_q == 6'd6) || (act_q == 6'd8));
  // R4
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> cnt_q < act_q);
  // R9
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_q != '0) |-> $stable(act_q));
  // R10
  stop_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && last && !en_i) |=> (!div_clk_o && !tick_o));
endmodule

// File: rtl/clkdiv_reload_top.sv
`timescale 1ns/1ps
module clkdiv_reload_top
  import clkdiv_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              div_clk_o,
  output logic              tick_o
);
  logic               en, reload;
  logic [RATIO_W-1:0] ratio;

  clkdiv_regs #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(0), .RATIO_ADDR(8), .CH_IDX(1),
    .EN_BASE(24), .TRIG_BIT(8), .RATIO_LSB(8)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .en_o(en),
    .reload_o(reload), .ratio_o(ratio)
  );

  clkdiv_core u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en), .reload_i(reload),
    .ratio_i(ratio), .div_clk_o(div_clk_o), .tick_o(tick_o)
  );
endmodule

// File: tb/sim_clkdiv_reload_top.sv
`timescale 1ns/1ps
module sim_clkdiv_reload_top;
  localparam logic [3:0]  A_CTRL  = 4'h0;
  localparam logic [3:0]  A_RATIO = 4'h8;
  localparam logic [31:0] EN    = 32'h0200_0000;
  localparam logic [31:0] FORCE = 32'h0000_0002;
  localparam logic [31:0] TRIG  = 32'h0000_0100;

  logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        div_o, tick_o;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  clkdiv_reload_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .div_clk_o(div_o), .tick_o(tick_o)
  );

  function automatic int exp_ratio(input int r);
    if (r < 4) return 4;
    if (r > 6) return 8;
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic measure(output int per, output int hi);
    logic prev; bit rise; int guard;
    prev = 1'b1; guard = 0;
    do begin @(negedge clk); rise = div_o && !prev; prev = div_o; guard++; end
    while (!rise && guard < 40);
    per = 0; hi = 0;
    do begin
      if (div_o) hi++;
      per++;
      @(negedge clk); rise = div_o && !prev; prev = div_o;
    end while (!rise && per < 40);
  endtask

  task automatic reload(input int r);
    wr(A_RATIO, 32'(r) << 8);
    wr(A_CTRL, EN | FORCE);
    wr(A_CTRL, EN | FORCE | TRIG);
    wr(A_CTRL, EN);
  endtask

  task automatic expect_period(input int r, input string tag);
    int per, hi;
    repeat (20) @(negedge clk);
    measure(per, hi);
    check(per == r, tag, per, r);
    check(hi == r / 2, tag, hi, r / 2);
  endtask

  initial begin
    #(5 * 150000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int per, hi, hi_cnt, rises, seen;
    logic prev;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    rd(A_CTRL, d);  check(d == 32'h0, "R1 ctrl reset", d, 0);
    rd(A_RATIO, d); check(d == 32'h400, "R1 ratio reset", d, 32'h400);
    seen = 0;
    repeat (20) begin @(negedge clk); if (div_o || tick_o) seen++; end
    check(seen == 0, "R1 output idle", seen, 0);

    // R2 readback of an arbitrary ratio word, control untouched
    wr(A_RATIO, 32'hA5A5_3F5A);
    rd(A_RATIO, d); check(d == 32'hA5A5_3F5A, "R2 ratio readback", d, 32'hA5A5_3F5A);
    rd(A_CTRL, d);  check(d == 32'h0, "R2 ctrl untouched", d, 0);
    wr(A_CTRL, 32'h00F0_0030);
    rd(A_CTRL, d);  check(d == 32'h00F0_0030, "R2 ctrl readback", d, 32'h00F0_0030);
    rd(A_RATIO, d); check(d == 32'hA5A5_3F5A, "R2 ratio untouched", d, 32'hA5A5_3F5A);
    wr(A_RATIO, 32'h400);
    wr(A_CTRL, 32'h0);
    // R3 gate off: output low
    seen = 0;
    repeat (20) begin @(negedge clk); if (div_o) seen++; end
    check(seen == 0, "R3 gated off", seen, 0);

    // R10 start timing, R3 enable, R4 ratio 4
    wr(A_CTRL, EN);
    @(negedge clk);
    check(div_o == 1'b1, "R10 start high", div_o, 1);
    check(tick_o == 1'b1, "R4 tick at period start", tick_o, 1);
    expect_period(4, "R4 ratio 4");

    // R5 ratio write without reload
    wr(A_RATIO, 32'(6) << 8);
    expect_period(4, "R5 no reload");

    // R6 trigger with no force; then force with trigger already high
    wr(A_CTRL, EN | TRIG);
    expect_period(4, "R6 trig no force");
    wr(A_CTRL, EN | TRIG | FORCE);
    expect_period(4, "R6 force after trig");
    wr(A_CTRL, EN);

    // R9 reload 4 -> 6 mid-run, every period old or new
    wr(A_CTRL, EN | FORCE);
    wr(A_CTRL, EN | FORCE | TRIG);
    for (int i = 0; i < 3; i++) begin
      measure(per, hi);
      check(per == 4 || per == 6, "R9 period old or new", per, 6);
      check(hi == per / 2, "R9 high phase", hi, per / 2);
    end
    check(per == 6, "R9 new ratio applied", per, 6);
    // R7 clear low bits
    wr(A_CTRL, EN);
    rd(A_CTRL, d); check(d == EN, "R7 ctrl after clear", d, EN);
    expect_period(6, "R7 ratio kept");

    // R4 odd ratio and ratio 8
    reload(5); expect_period(5, "R4 ratio 5");
    reload(8); expect_period(8, "R4 ratio 8");

    // R8 clamp corners
    reload(2);  expect_period(4, "R8 clamp 2");
    reload(0);  expect_period(4, "R8 clamp 0");
    reload(7);  expect_period(8, "R8 clamp 7");
    reload(63); expect_period(8, "R8 clamp 63");

    // R8 R9 random ratio fields, trigger at random phase
    for (int i = 0; i < 12; i++) begin
      int r;
      r = $urandom % 64;
      repeat ($urandom % 8) @(negedge clk);
      reload(r);
      expect_period(exp_ratio(r), "R8 random reload");
    end

    // R10 stop: finish period, no new rising edge
    reload(8);
    repeat (20) @(negedge clk);
    repeat ($urandom % 8) @(negedge clk);
    wr(A_CTRL, 32'h0);
    prev = div_o; rises = 0; hi_cnt = 0;
    repeat (30) begin
      @(negedge clk);
      if (div_o && !prev) rises++;
      if (div_o) hi_cnt++;
      prev = div_o;
    end
    check(rises == 0, "R10 no edge after stop", rises, 0);
    check(div_o == 1'b0, "R10 low after stop", div_o, 0);
    check(hi_cnt <= 4, "R10 finish period only", hi_cnt, 4);
    // R10 restart
    wr(A_CTRL, EN);
    check(div_o == 1'b0, "R10 low before restart", div_o, 0);
    @(negedge clk);
    check(div_o == 1'b1, "R10 restart high", div_o, 1);
    expect_period(8, "R10 ratio kept over stop");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule